// File: doc/BRIEF.md
# Aliased Set/Clear Interrupt Register

This block holds one 64-bit miscellaneous control word behind a register bus that accepts doubleword accesses only. Software reaches the word through three neighbouring offsets. The base offset reads the word and overwrites it. The offset two above the base ORs the write data into the word. The offset one above the base either ANDs the write data into the word or clears it, and the parameter `CLEAR_ALIAS` chooses which. Only the top 19 bits of the word are implemented. Every update forces the other bits to zero.

The most significant bit of the word drives a level interrupt. A local raise input lets on-chip logic post a message: it sets the interrupt bit and a shared-memory notification bit in one update. Read data is registered and comes back one cycle after the read strobe with a one-cycle valid pulse.

Top module: `misc_ctrl_reg`

## Requirements
- R1: After reset the word reads as zero, `irq_o` is low and `rvalid_o` is low.
- R2: The register offset is `addr_i` shifted right by 3, so the low three address bits are ignored. An access with `dword_i` low has no effect on the word and reads as zero.
- R3: A write to the base offset (0x4020 when `CLEAR_ALIAS`=0, 0x6080 when `CLEAR_ALIAS`=1) replaces the word with the write data.
- R4: A write to base+2 replaces the word with old OR data.
- R5: A write to base+1 gives old AND data when `CLEAR_ALIAS`=0. When `CLEAR_ALIAS`=1 it gives zero, whatever the data.
- R6: After any update, bits 63..45 (MSB-first bits 0..18) keep their computed value and bits 44..0 are zero.
- R7: `irq_o` equals bit 63 of the word and follows every change of the word.
- R8: `raise_i` ORs bit 63 and bit 60 (MSB-first bits 0 and 3) into the word, under the same mask.
- R9: When a bus write and `raise_i` fall in the same cycle, the write result is computed first and the raise bits are then ORed into it.
- R10: Offsets other than base, base+1 and base+2 read as zero, and writes to them leave the word unchanged.
- R11: A read strobe (`req_i` high, `we_i` low) gives `rvalid_o` high for exactly one cycle on the next cycle. `rdata_o` then holds the word as it was when the strobe was sampled, or zero for a read that does not hit the base offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| dword_i | input | 1 | Access is a full 8-byte access |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| raise_i | input | 1 | Local raise-message request |
| rdata_o | output | DATA_W | Registered read data |
| rvalid_o | output | 1 | Read data valid pulse |
| irq_o | output | 1 | Level interrupt, bit 63 of the word |

## Verification
A bus write and a local raise request can land on the same clock edge, and the merge order then decides the result. The bench provokes this by asserting `raise_i` in the same cycle as a direct write with a mid-field bit set. It does the same with an AND of zero in one variant and a clear in the other. It then reads the word back and expects the write result with bits 63 and 60 added. If the write result came after the raise bits, the interrupt bit would be lost.

// File: rtl/misc_reg_pkg.sv
package misc_reg_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_DIRECT = 3'd1,
    OP_AND    = 3'd2,
    OP_CLR    = 3'd3,
    OP_OR     = 3'd4
  } wr_op_e;
endpackage

// File: rtl/misc_reg_decode.sv
module misc_reg_decode
  import misc_reg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter bit          CLEAR_ALIAS = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              dword_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_op_e            op_o,
  output logic              rd_en_o,
  output logic              rd_hit_o
);
  localparam int unsigned OFF_W    = ADDR_W - 3;
  localparam int unsigned BASE_INT = CLEAR_ALIAS ? 32'h6080 : 32'h4020;
  localparam logic [OFF_W-1:0] BASE_OFF = OFF_W'(BASE_INT);
  localparam logic [OFF_W-1:0] ALT_OFF  = OFF_W'(BASE_INT + 1);
  localparam logic [OFF_W-1:0] OR_OFF   = OFF_W'(BASE_INT + 2);
  localparam wr_op_e ALT_OP = CLEAR_ALIAS ? OP_CLR : OP_AND;

  logic [OFF_W-1:0] off;
  logic             ok;

  assign off      = addr_i[ADDR_W-1:3];
  assign ok       = req_i && dword_i;
  assign rd_en_o  = req_i && !we_i;
  assign rd_hit_o = ok && !we_i && (off == BASE_OFF);

  always_comb begin
    op_o = OP_NONE;
    if (ok && we_i) begin
      if (off == BASE_OFF)     op_o = OP_DIRECT;
      else if (off == ALT_OFF) op_o = ALT_OP;
      else if (off == OR_OFF)  op_o = OP_OR;
    end
  end

  assert_partial_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dword_i |-> (op_o == OP_NONE && !rd_hit_o));
  assert_unmapped_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off != BASE_OFF && off != ALT_OFF && off != OR_OFF) |-> (op_o == OP_NONE && !rd_hit_o));
endmodule

// File: rtl/misc_reg_update.sv
module misc_reg_update
  import misc_reg_pkg::*;
#(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned KEEP_BITS   = 19,
  parameter int unsigned IRQ_POS     = 0,
  parameter int unsigned MSG_POS     = 3,
  parameter bit          CLEAR_ALIAS = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_op_e            op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              raise_i,
  output logic [DATA_W-1:0] q_o
);
  localparam logic [DATA_W-1:0] KEEP_MASK  = ~({DATA_W{1'b1}} >> KEEP_BITS);
  localparam logic [DATA_W-1:0] ONE        = DATA_W'(1);
  localparam logic [DATA_W-1:0] RAISE_MASK = (ONE << (DATA_W-1-IRQ_POS)) |
                                             (ONE << (DATA_W-1-MSG_POS));

  logic [DATA_W-1:0] q, merged, d;

  always_comb begin
    unique case (op_i)
      OP_DIRECT: merged = wdata_i;
      OP_AND:    merged = q & wdata_i;
      OP_CLR:    merged = '0;
      OP_OR:     merged = q | wdata_i;
      default:   merged = q;
    endcase
    // write result first, then raise bits on top
    if (raise_i) merged = merged | RAISE_MASK;
    d = merged & KEEP_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign q_o = q;

  assert_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q & ~KEEP_MASK) == '0);
  assert_raise_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_i |=> ((q & RAISE_MASK) == RAISE_MASK));
  assert_or_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_OR) |=> ((q & $past(q)) == $past(q)));
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NONE && !raise_i) |=> $stable(q));

  generate
    if (CLEAR_ALIAS) begin : g_clr_chk
      assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_CLR && !raise_i) |=> (q == '0));
    end else begin : g_and_chk
      assert_and_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_AND && !raise_i) |=> ((q & ~$past(q)) == '0));
    end
  endgenerate
endmodule

// File: rtl/misc_reg_rdport.sv
module misc_reg_rdport #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              rd_hit_i,
  input  logic [DATA_W-1:0] value_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_hit_i ? value_i : '0;
    end
  end

  assert_rvalid_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  assert_rvalid_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
endmodule

// File: rtl/misc_ctrl_reg.sv
module misc_ctrl_reg
  import misc_reg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned KEEP_BITS   = 19,
  parameter bit          CLEAR_ALIAS = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              dword_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              raise_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  wr_op_e            op;
  logic              rd_en, rd_hit;
  logic [DATA_W-1:0] q;

  misc_reg_decode #(.ADDR_W(ADDR_W), .CLEAR_ALIAS(CLEAR_ALIAS)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .dword_i(dword_i),
    .addr_i(addr_i), .op_o(op), .rd_en_o(rd_en), .rd_hit_o(rd_hit));

  misc_reg_update #(.DATA_W(DATA_W), .KEEP_BITS(KEEP_BITS), .IRQ_POS(0), .MSG_POS(3),
                    .CLEAR_ALIAS(CLEAR_ALIAS)) u_upd (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .wdata_i(wdata_i), .raise_i(raise_i),
    .q_o(q));

  misc_reg_rdport #(.DATA_W(DATA_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en), .rd_hit_i(rd_hit), .value_i(q),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o));

  // interrupt is MSB-first bit 0
  assign irq_o = q[DATA_W-1];

  assert_raise_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_i |=> irq_o);
endmodule

// File: tb/tb_misc_ctrl_reg.sv
`timescale 1ns/1ps
module tb_misc_ctrl_reg;
  localparam logic [63:0] MASK = 64'hFFFF_E000_0000_0000;
  localparam logic [31:0] BA = 32'h4020;
  localparam logic [31:0] BB = 32'h6080;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] req, we, dw, raise, rvalid, irq;
  logic [31:0] addr [2];
  logic [63:0] wd [2];
  logic [63:0] rdata [2];

  int total = 0;
  int bad = 0;
  logic [63:0] qa_exp[$];
  string       qa_tag[$];
  logic [63:0] qb_exp[$];
  string       qb_tag[$];

  misc_ctrl_reg #(.CLEAR_ALIAS(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[0]), .we_i(we[0]), .dword_i(dw[0]),
    .addr_i(addr[0]), .wdata_i(wd[0]), .raise_i(raise[0]), .rdata_o(rdata[0]),
    .rvalid_o(rvalid[0]), .irq_o(irq[0]));

  misc_ctrl_reg #(.CLEAR_ALIAS(1'b1)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[1]), .we_i(we[1]), .dword_i(dw[1]),
    .addr_i(addr[1]), .wdata_i(wd[1]), .raise_i(raise[1]), .rdata_o(rdata[1]),
    .rvalid_o(rvalid[1]), .irq_o(irq[1]));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitors: pop expected read data on each valid pulse
  always @(negedge clk) if (rst_n && rvalid[0]) begin
    if (qa_exp.size() == 0) chk("R11 unexpected rvalid A", 64'd1, 64'd0);
    else chk(qa_tag.pop_front(), rdata[0], qa_exp.pop_front());
  end
  always @(negedge clk) if (rst_n && rvalid[1]) begin
    if (qb_exp.size() == 0) chk("R11 unexpected rvalid B", 64'd1, 64'd0);
    else chk(qb_tag.pop_front(), rdata[1], qb_exp.pop_front());
  end

  task automatic wr(int v, logic [31:0] off, logic [63:0] d, bit rs = 0, bit full = 1);
    @(negedge clk);
    req[v] = 1'b1; we[v] = 1'b1; dw[v] = full; addr[v] = {off[28:0], 3'b000};
    wd[v] = d; raise[v] = rs;
    @(negedge clk);
    req[v] = 1'b0; we[v] = 1'b0; raise[v] = 1'b0;
  endtask

  task automatic rd(int v, logic [31:0] off, logic [63:0] exp, string tag,
                    bit full = 1, logic [2:0] lo = 3'b000);
    @(negedge clk);
    req[v] = 1'b1; we[v] = 1'b0; dw[v] = full; addr[v] = {off[28:0], lo};
    if (v == 0) begin qa_exp.push_back(exp); qa_tag.push_back(tag); end
    else        begin qb_exp.push_back(exp); qb_tag.push_back(tag); end
    @(negedge clk);
    req[v] = 1'b0;
  endtask

  task automatic pulse_raise(int v);
    @(negedge clk); raise[v] = 1'b1;
    @(negedge clk); raise[v] = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    req = '0; we = '0; dw = '1; raise = '0;
    for (int i = 0; i < 2; i++) begin addr[i] = '0; wd[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 rvalid in reset", {63'd0, rvalid[0]}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {63'd0, irq[0]}, 64'd0);
    chk("R1 rvalid after reset", {63'd0, rvalid[0]}, 64'd0);
    rd(0, BA, 64'd0, "R1 reset value");

    // variant A: AND alias
    wr(0, BA, '1);
    chk("R7 irq high after direct write", {63'd0, irq[0]}, 64'd1);
    rd(0, BA, MASK, "R3 R6 direct write masked");
    wr(0, BA + 1, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R7 irq low after and", {63'd0, irq[0]}, 64'd0);
    rd(0, BA, 64'h7FFF_E000_0000_0000, "R5 and-merge");
    wr(0, BA + 2, 64'h8000_0000_0000_0001);
    chk("R7 irq high after or", {63'd0, irq[0]}, 64'd1);
    rd(0, BA, MASK, "R4 R6 or-merge masked");
    wr(0, BA, 64'd0);
    chk("R7 irq low after zero write", {63'd0, irq[0]}, 64'd0);
    pulse_raise(0);
    chk("R8 irq from raise", {63'd0, irq[0]}, 64'd1);
    rd(0, BA, 64'h9000_0000_0000_0000, "R8 raise bits");
    wr(0, BA, 64'h0000_4000_0000_0000, 1'b1);
    rd(0, BA, 64'h9000_4000_0000_0000, "R9 direct write then raise");
    wr(0, BA + 1, 64'd0, 1'b1);
    rd(0, BA, 64'h9000_0000_0000_0000, "R9 and zero then raise");
    wr(0, BA + 3, '1);
    wr(0, BA - 1, '1);
    rd(0, BA, 64'h9000_0000_0000_0000, "R10 unmapped writes ignored");
    rd(0, BA + 3, 64'd0, "R10 unmapped read zero");
    rd(0, BA + 2, 64'd0, "R10 alias read zero");
    wr(0, BA, 64'd0, 1'b0, 1'b0);
    rd(0, BA, 64'h9000_0000_0000_0000, "R2 partial write ignored");
    rd(0, BA, 64'd0, "R2 partial read zero", 1'b0);
    rd(0, BA, 64'h9000_0000_0000_0000, "R2 low address bits ignored", 1'b1, 3'b101);
    @(negedge clk);
    chk("R11 rvalid single pulse", {63'd0, rvalid[0]}, 64'd0);

    // variant B: clear alias
    wr(1, BB, '1);
    rd(1, BB, MASK, "R3 R6 variant B direct write");
    wr(1, BB + 1, 64'h1234_5678_9ABC_DEF0);
    chk("R5 variant B irq after clear", {63'd0, irq[1]}, 64'd0);
    rd(1, BB, 64'd0, "R5 clear ignores data");
    wr(1, BB + 2, 64'h0800_0000_0000_0000);
    rd(1, BB, 64'h0800_0000_0000_0000, "R4 variant B or-merge");
    rd(1, BA, 64'd0, "R10 variant B other base reads zero");
    wr(1, BB + 1, '1, 1'b1);
    rd(1, BB, 64'h9000_0000_0000_0000, "R9 clear then raise");
    chk("R7 variant B irq", {63'd0, irq[1]}, 64'd1);

    repeat (3) @(negedge clk);
    if (qa_exp.size() != 0 || qb_exp.size() != 0)
      chk("R11 missing read responses", 64'(qa_exp.size() + qb_exp.size()), 64'd0);
    summary();
  end
endmodule